// File: doc/BRIEF.md
# Phase-Tagged Completion Ring

This block models the device side of a completion ring kept in host memory, together with a reference poller that reads it back. Completion records arrive on a valid/ready input. For each record the writer stores the payload into the next ring slot as a series of 32-bit memory writes. It then writes one status word that carries an ownership phase bit and a checksum of the payload. The status word is always the last write of the entry. Because the phase bit inverts on every lap of the ring, a consumed slot never has to be cleared.

The poller repeatedly reads the status word of the slot at its head. It reads the payload words only after the phase bit equals the phase it expects for the current lap. It then recomputes the checksum, presents the entry on a valid/ready output, and advances. If the recomputed checksum differs from the one in the status word, it raises an error flag with the entry. This is how a writer or memory path that lets the status word land before the payload is caught. The writer stops taking records when a full ring of entries is still unreleased by the poller, so a slot the poller owns is never rewritten.

Top module: `cq_phase_ring`

## Requirements
- R1: A record is taken on a cycle where cpl_valid and cpl_ready are both high. Its payload is then written as PAY_WORDS memory writes, then one status write, all to the same slot. Word w of a slot sits at address slot*4 + w and holds cpl_data[32w+31:32w]. The status word sits at word offset PAY_WORDS (2 by default). An address and its data hold steady while mem_wr_ready is low.
- R2: The status word has the phase in bit 0 and zero in bits 15:1. Bits 31:16 hold the XOR of all 16-bit halves of the payload words.
- R3: The producer index counts records taken, starting at 0 after reset. A record's slot is that index modulo DEPTH (1024). The phase written is 1 on the first lap and inverts each time the slot index wraps from DEPTH-1 to 0.
- R4: cpl_ready is high only when the writer has finished the previous record's writes and the number of unreleased entries (producer index minus consumer index) is below DEPTH. When that number equals DEPTH, cpl_ready is low.
- R5: While the ring holds DEPTH unreleased entries, no new memory write is issued, so the slot at the consumer head is never rewritten.
- R6: The poller reads only the slot at its consumer index. It reads the status word first and reads a payload word only after that status word showed the expected phase. The expected phase starts at 1 and inverts when the consumer index wraps its slot from DEPTH-1 to 0.
- R7: A slot whose status phase differs from the expected phase is ignored. While the ring is empty, including when slots still hold the previous lap's entries, out_valid stays low.
- R8: Entries leave in the order they were taken. out_valid, out_data and out_err stay steady until out_ready is high, and the consumer index advances by one on each output handshake.
- R9: out_err is high for an entry exactly when the checksum recomputed from the payload read back differs from bits 31:16 of its status word. A status word that lands in memory before its payload is therefore reported.
- R10: After reset cpl_ready is high, out_valid is low, mem_wr_valid is low and both indices are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpl_valid | input | 1 | Completion record offered |
| cpl_ready | output | 1 | Writer can take a record |
| cpl_data | input | PAY_WORDS*32 | Completion payload |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| mem_wr_addr | output | log2(DEPTH)+2 | Word address of the write |
| mem_wr_data | output | 32 | Write data |
| rd_en | output | 1 | Poller read request |
| rd_addr | output | log2(DEPTH)+2 | Word address of the read |
| rd_data | input | 32 | Read data, returned the cycle after rd_en |
| out_valid | output | 1 | Consumed entry available |
| out_ready | input | 1 | Downstream takes the entry |
| out_data | output | PAY_WORDS*32 | Payload as read back |
| out_err | output | 1 | Checksum mismatch on this entry |

## Verification
The properties assume that memory returns the addressed word on rd_data one cycle after rd_en, and that writes reach that memory in the order they are accepted. Under this assumption the phase check and the checksum check describe real ownership. The bench memory keeps to this during normal traffic, with a random write-ready pattern that delays each write by an arbitrary number of cycles. It breaks the assumption only once, on purpose: it holds back the payload of one entry for 40 cycles after letting its status word through, so that the poller's error flag must fire. Output stalls are random, and one phase holds out_ready low until the ring fills.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        CS_STAT_RD,
        CS_STAT_CHK,
        CS_PAY_RD,
        CS_PAY_GET,
        CS_OUT
    } cq_cstate_e;

    function automatic logic [15:0] fold32(input logic [WORD_W-1:0] w);
        return w[31:16] ^ w[15:0];
    endfunction

endpackage

// File: rtl/cq_writer.sv
module cq_writer #(
    parameter int DEPTH     = 1024,
    parameter int PAY_WORDS = 2,
    parameter int IDX_W     = 32,
    localparam int SLOT_W   = $clog2(DEPTH),
    localparam int STRIDE_W = $clog2(PAY_WORDS + 1),
    localparam int ADDR_W   = SLOT_W + STRIDE_W,
    localparam int PAY_W    = PAY_WORDS * cq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              room,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PAY_W-1:0]  in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [IDX_W-1:0]  prod_idx
);
    localparam logic [STRIDE_W-1:0] STAT_WORD = STRIDE_W'(PAY_WORDS);
    localparam logic [SLOT_W-1:0]   LAST_SLOT = SLOT_W'(DEPTH - 1);

    typedef struct packed {
        logic                busy;
        logic [STRIDE_W-1:0] word;
        logic [PAY_W-1:0]    data;
        logic [SLOT_W-1:0]   slot;
        logic                ent_phase;
        logic                phase;
        logic [IDX_W-1:0]    prod;
    } wst_t;

    wst_t st_d, st_q;
    logic [31:0] pay_word;
    logic [15:0] fold;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.busy && room;
        if (st_q.busy && wr_ready) begin
            if (st_q.word == STAT_WORD) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.word = st_q.word + 1'b1;
            end
        end
        if (in_valid && in_ready) begin
            st_d.busy      = 1'b1;
            st_d.word      = '0;
            st_d.data      = in_data;
            st_d.slot      = st_q.prod[SLOT_W-1:0];
            st_d.ent_phase = st_q.phase;
            st_d.prod      = st_q.prod + 1'b1;
            if (st_q.prod[SLOT_W-1:0] == LAST_SLOT) begin
                st_d.phase = ~st_q.phase;
            end
        end
    end

    always_comb begin
        pay_word = '0;
        fold     = '0;
        for (int w = 0; w < PAY_WORDS; w++) begin
            fold = fold ^ cq_pkg::fold32(st_q.data[w*32 +: 32]);
            if (st_q.word == STRIDE_W'(w)) begin
                pay_word = st_q.data[w*32 +: 32];
            end
        end
    end

    assign wr_valid = st_q.busy;
    assign wr_addr  = {st_q.slot, st_q.word};
    assign wr_data  = (st_q.word == STAT_WORD) ? {fold, 15'b0, st_q.ent_phase} : pay_word;
    assign prod_idx = st_q.prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cq_consumer.sv
module cq_consumer #(
    parameter int DEPTH     = 1024,
    parameter int PAY_WORDS = 2,
    parameter int IDX_W     = 32,
    localparam int SLOT_W   = $clog2(DEPTH),
    localparam int STRIDE_W = $clog2(PAY_WORDS + 1),
    localparam int ADDR_W   = SLOT_W + STRIDE_W,
    localparam int PAY_W    = PAY_WORDS * cq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAY_W-1:0]  out_data,
    output logic              out_err,
    output logic [IDX_W-1:0]  cons_idx,
    output logic              exp_phase
);
    import cq_pkg::*;

    localparam logic [STRIDE_W-1:0] STAT_WORD = STRIDE_W'(PAY_WORDS);
    localparam logic [STRIDE_W-1:0] LAST_PAY  = STRIDE_W'(PAY_WORDS - 1);
    localparam logic [SLOT_W-1:0]   LAST_SLOT = SLOT_W'(DEPTH - 1);

    typedef struct packed {
        cq_cstate_e          state;
        logic [STRIDE_W-1:0] word;
        logic [PAY_W-1:0]    data;
        logic [15:0]         sfold;
        logic [IDX_W-1:0]    cons;
        logic                phase;
    } cst_t;

    cst_t st_d, st_q;
    logic [SLOT_W-1:0] head;
    logic [15:0] calc_fold;

    assign head = st_q.cons[SLOT_W-1:0];

    always_comb begin
        st_d      = st_q;
        rd_en     = 1'b0;
        rd_addr   = {head, STAT_WORD};
        out_valid = 1'b0;
        case (st_q.state)
            CS_STAT_RD: begin
                rd_en      = 1'b1;
                st_d.state = CS_STAT_CHK;
            end
            CS_STAT_CHK: begin
                if (rd_data[0] == st_q.phase) begin
                    st_d.sfold = rd_data[31:16];
                    st_d.word  = '0;
                    st_d.state = CS_PAY_RD;
                end else begin
                    st_d.state = CS_STAT_RD;
                end
            end
            CS_PAY_RD: begin
                rd_en      = 1'b1;
                rd_addr    = {head, st_q.word};
                st_d.state = CS_PAY_GET;
            end
            CS_PAY_GET: begin
                for (int w = 0; w < PAY_WORDS; w++) begin
                    if (st_q.word == STRIDE_W'(w)) begin
                        st_d.data[w*32 +: 32] = rd_data;
                    end
                end
                if (st_q.word == LAST_PAY) begin
                    st_d.state = CS_OUT;
                end else begin
                    st_d.word  = st_q.word + 1'b1;
                    st_d.state = CS_PAY_RD;
                end
            end
            CS_OUT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    st_d.cons  = st_q.cons + 1'b1;
                    st_d.state = CS_STAT_RD;
                    if (head == LAST_SLOT) begin
                        st_d.phase = ~st_q.phase;
                    end
                end
            end
            default: st_d.state = CS_STAT_RD;
        endcase
    end

    always_comb begin
        calc_fold = '0;
        for (int w = 0; w < PAY_WORDS; w++) begin
            calc_fold = calc_fold ^ fold32(st_q.data[w*32 +: 32]);
        end
    end

    assign out_data  = st_q.data;
    assign out_err   = (calc_fold != st_q.sfold);
    assign cons_idx  = st_q.cons;
    assign exp_phase = st_q.phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= CS_STAT_RD;
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cq_phase_ring.sv
module cq_phase_ring #(
    parameter int DEPTH     = 1024,
    parameter int PAY_WORDS = 2,
    parameter int IDX_W     = 32,
    localparam int SLOT_W   = $clog2(DEPTH),
    localparam int STRIDE_W = $clog2(PAY_WORDS + 1),
    localparam int ADDR_W   = SLOT_W + STRIDE_W,
    localparam int PAY_W    = PAY_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [PAY_W-1:0]  cpl_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAY_W-1:0]  out_data,
    output logic              out_err
);
    logic [IDX_W-1:0] prod_idx;
    logic [IDX_W-1:0] cons_idx;
    logic             cons_phase;
    logic             room;

    assign room = (prod_idx - cons_idx) != IDX_W'(DEPTH);

    cq_writer #(.DEPTH(DEPTH), .PAY_WORDS(PAY_WORDS), .IDX_W(IDX_W)) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .room     (room),
        .in_valid (cpl_valid),
        .in_ready (cpl_ready),
        .in_data  (cpl_data),
        .wr_valid (mem_wr_valid),
        .wr_ready (mem_wr_ready),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data),
        .prod_idx (prod_idx)
    );

    cq_consumer #(.DEPTH(DEPTH), .PAY_WORDS(PAY_WORDS), .IDX_W(IDX_W)) u_consumer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_err   (out_err),
        .cons_idx  (cons_idx),
        .exp_phase (cons_phase)
    );

endmodule

// File: rtl/cq_phase_ring_chk.sv
module cq_phase_ring_chk #(
    parameter int DEPTH     = 1024,
    parameter int PAY_WORDS = 2,
    parameter int IDX_W     = 32,
    localparam int SLOT_W   = $clog2(DEPTH),
    localparam int STRIDE_W = $clog2(PAY_WORDS + 1),
    localparam int ADDR_W   = SLOT_W + STRIDE_W,
    localparam int PAY_W    = PAY_WORDS * 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpl_ready,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [31:0]       mem_wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PAY_W-1:0]  out_data,
    input logic              out_err,
    input logic [IDX_W-1:0]  prod_idx,
    input logic [IDX_W-1:0]  cons_idx,
    input logic              cons_phase
);
    localparam logic [STRIDE_W-1:0] STAT_WORD = STRIDE_W'(PAY_WORDS);

    logic [STRIDE_W-1:0] wr_word, rd_word;
    logic [STRIDE_W:0]   pay_cnt_q;
    logic                stat_rd_q, ph_ok_q;

    assign wr_word = mem_wr_addr[STRIDE_W-1:0];
    assign rd_word = rd_addr[STRIDE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_cnt_q <= '0;
            stat_rd_q <= 1'b0;
            ph_ok_q   <= 1'b0;
        end else begin
            if (mem_wr_valid && mem_wr_ready) begin
                pay_cnt_q <= (wr_word == STAT_WORD) ? '0 : pay_cnt_q + 1'b1;
            end
            stat_rd_q <= rd_en && (rd_word == STAT_WORD);
            if (out_valid && out_ready) begin
                ph_ok_q <= 1'b0;
            end else if (stat_rd_q && (rd_data[0] == cons_phase)) begin
                ph_ok_q <= 1'b1;
            end
        end
    end

    // R1: status word follows all payload words of its entry
    a_r1_status_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && wr_word == STAT_WORD) |-> (pay_cnt_q == (STRIDE_W+1)'(PAY_WORDS)));

    // R1: write request holds while stalled
    a_r1_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R4: no record accepted with a full ring outstanding
    a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((prod_idx - cons_idx) == IDX_W'(DEPTH)) |-> !cpl_ready);

    // R5: writes only target reserved, unreleased-window slots
    a_r5_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> ((prod_idx != cons_idx) && ((prod_idx - cons_idx) <= IDX_W'(DEPTH))));

    // R6: poller reads only its head slot
    a_r6_head_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[ADDR_W-1:STRIDE_W] == cons_idx[SLOT_W-1:0]));

    // R6: payload read only after the matching phase was seen
    a_r6_payload_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_word != STAT_WORD) |-> ph_ok_q);

    // R6: expected phase inverts exactly on a slot wrap
    a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cons_idx) && cons_idx[SLOT_W-1:0] == '0) |-> (cons_phase != $past(cons_phase)));

    a_r6_phase_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cons_idx) && cons_idx[SLOT_W-1:0] != '0) |-> $stable(cons_phase));

    // R8: consumer index advances by one per handshake only
    a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cons_idx) |-> (cons_idx == $past(cons_idx) + 1'b1));

    // R8: output held while stalled
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_err)));

endmodule

bind cq_phase_ring cq_phase_ring_chk #(.DEPTH(DEPTH), .PAY_WORDS(PAY_WORDS), .IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpl_ready    (cpl_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_err      (out_err),
    .prod_idx     (prod_idx),
    .cons_idx     (cons_idx),
    .cons_phase   (cons_phase)
);

// File: tb/cq_phase_ring_tb_top.sv
module cq_phase_ring_tb_top;
    localparam int DEPTH     = 1024;
    localparam int PAY_WORDS = 2;
    localparam int PAY_W     = 64;
    localparam int ADDR_W    = 12;
    localparam int MEM_N     = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              cpl_valid = 1'b0;
    logic              cpl_ready;
    logic [PAY_W-1:0]  cpl_data = '0;
    logic              mem_wr_valid;
    logic              mem_wr_ready = 1'b0;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [31:0]       rd_data;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [PAY_W-1:0]  out_data;
    logic              out_err;

    cq_phase_ring #(.DEPTH(DEPTH), .PAY_WORDS(PAY_WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_err(out_err)
    );

    int n_chk = 0, n_fail = 0, n_acc = 0, n_out = 0;
    int wr_mode = 0, out_mode = 0;
    logic inject_req = 1'b0;
    logic [PAY_W:0]      sb[$];
    logic [ADDR_W+31:0]  wq[$];

    task automatic check(input bit ok, input string tag, input logic [PAY_W:0] act, input logic [PAY_W:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [PAY_W-1:0] mk(input int s);
        logic [31:0] lo, hi;
        lo = 32'(s);
        hi = (32'(s) << 8) ^ 32'hA5A5_0000;
        return {hi, lo};
    endfunction

    function automatic logic [15:0] fold(input logic [PAY_W-1:0] d);
        return d[15:0] ^ d[31:16] ^ d[47:32] ^ d[63:48];
    endfunction

    // memory model: one-cycle read, in-order writes, optional payload hold-back
    logic [31:0] mem [MEM_N];
    logic [ADDR_W-1:0] hold_a [2];
    logic [31:0]       hold_d [2];
    int hold_n, rel;
    logic inj_seen;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
            rd_data  <= '0;
            hold_n   <= 0;
            rel      <= 0;
            inj_seen <= 1'b0;
        end else begin
            if (rd_en) rd_data <= mem[rd_addr];
            if (mem_wr_valid && mem_wr_ready) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R1 unexpected memory write", {21'b0, mem_wr_addr, mem_wr_data}, '0);
                end else begin
                    logic [ADDR_W+31:0] e;
                    e = wq.pop_front();
                    // R1 order/address, R2 status format, R3 phase per lap
                    check({mem_wr_addr, mem_wr_data} == e, "R1 R2 R3 write sequence",
                          {21'b0, mem_wr_addr, mem_wr_data}, {21'b0, e});
                end
                if (inject_req && !inj_seen && mem_wr_addr[1:0] != 2'd2) begin
                    hold_a[hold_n] <= mem_wr_addr;
                    hold_d[hold_n] <= mem_wr_data;
                    hold_n <= hold_n + 1;
                end else begin
                    mem[mem_wr_addr] <= mem_wr_data;
                    if (inject_req && !inj_seen) begin
                        inj_seen <= 1'b1;
                        rel      <= 40;
                    end
                end
            end
            if (rel != 0) begin
                rel <= rel - 1;
                if (rel == 1) begin
                    for (int h = 0; h < hold_n; h++) mem[hold_a[h]] <= hold_d[h];
                end
            end
            if (!inject_req) begin
                inj_seen <= 1'b0;
                hold_n   <= 0;
            end
        end
    end

    always @(posedge clk) begin
        mem_wr_ready <= (wr_mode == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
        out_ready    <= (out_mode == 0) ? 1'b1 :
                        (out_mode == 2) ? 1'b0 : ($urandom_range(0, 2) != 0);
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 output with nothing queued", {out_err, out_data}, '0);
            end else begin
                logic [PAY_W:0] e;
                e = sb.pop_front();
                check({out_err, out_data} == e, "R6 R8 R9 consumed entry", {out_err, out_data}, e);
                n_out++;
            end
        end
    end

    task automatic push(input int seq, input bit inj);
        logic [PAY_W-1:0] d;
        int slot;
        logic ph;
        d = mk(seq);
        cpl_valid = 1'b1;
        cpl_data  = d;
        while (!cpl_ready) @(negedge clk);
        slot = n_acc % DEPTH;
        ph   = ((n_acc / DEPTH) % 2) == 0;
        wq.push_back({ADDR_W'(slot * 4 + 0), d[31:0]});
        wq.push_back({ADDR_W'(slot * 4 + 1), d[63:32]});
        wq.push_back({ADDR_W'(slot * 4 + 2), fold(d), 15'b0, ph});
        sb.push_back(inj ? {1'b1, 64'b0} : {1'b0, d});
        n_acc++;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || wq.size() != 0) @(negedge clk);
    endtask

    task automatic idle_check(input string tag);
        int bad;
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (out_valid) bad++;
        end
        check(bad == 0, tag, 65'(bad), '0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(cpl_ready == 1'b1, "R10 cpl_ready after reset", 65'(cpl_ready), 65'd1);
        check(out_valid == 1'b0, "R10 out_valid after reset", 65'(out_valid), 65'd0);
        check(mem_wr_valid == 1'b0, "R10 mem_wr_valid after reset", 65'(mem_wr_valid), 65'd0);

        // R9 status-first injection on a fresh slot
        inject_req = 1'b1;
        push(0, 1'b1);
        drain();
        repeat (50) @(negedge clk);
        inject_req = 1'b0;
        @(negedge clk);

        // R1 R3 R6 R8 random traffic with random write and output stalls
        wr_mode = 1;
        out_mode = 1;
        for (int i = 1; i <= 1500; i++) begin
            push(i, 1'b0);
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 4)) @(negedge clk);
        end
        drain();
        out_mode = 0;
        // R7 empty ring in second lap: old-phase slots are ignored
        idle_check("R7 no output while empty mid-lap");

        // R4 R5 fill the ring with output stalled
        wr_mode = 0;
        out_mode = 2;
        repeat (3) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) push(5000 + i, 1'b0);
        repeat (5) @(negedge clk);
        check(cpl_ready == 1'b0, "R4 ready low with full ring", 65'(cpl_ready), 65'd0);
        begin
            int wr_seen, rdy_seen;
            wr_seen = 0;
            rdy_seen = 0;
            repeat (30) begin
                @(negedge clk);
                if (mem_wr_valid) wr_seen++;
                if (cpl_ready) rdy_seen++;
            end
            check(wr_seen == 0, "R5 no write while ring full", 65'(wr_seen), '0);
            check(rdy_seen == 0, "R4 ready stays low while full", 65'(rdy_seen), '0);
        end
        check(sb.size() == DEPTH, "R4 entries outstanding at full", 65'(sb.size()), 65'(DEPTH));
        out_mode = 0;
        drain();
        check(n_out == n_acc, "R8 every entry consumed once", 65'(n_out), 65'(n_acc));
        check(cpl_ready == 1'b1, "R4 ready returns after drain", 65'(cpl_ready), 65'd1);

        // a few more across the next boundary, then final empty check
        wr_mode = 1;
        for (int i = 0; i < 5; i++) push(9000 + i, 1'b0);
        drain();
        idle_check("R7 no output after final drain");

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule